// File: doc/BRIEF.md
# Three-Level Nesting Vectored Interrupt Controller

This block sits between a set of interrupt request lines and a small CPU core. Each line stands for one vector. Each vector has a one-bit priority setting. The block latches requests and picks a winner by level and then by vector index. It raises a request to the CPU together with the winner's entry address. The block tracks which levels are currently being serviced, so that a handler can be pre-empted only by a request at a strictly higher level.

There are three levels: top, high and low. Only the first two vectors can be raised to the top level. All other vectors can be raised to the high level. A vector whose setting bit is clear runs at the low level.

The CPU takes an issued interrupt by pulsing `ack_i` while `irq_o` is high. It signals the end of a handler by pulsing `reti_i`. Arbitration works on the state for the next cycle, and the outputs are registered. A request sampled at a clock edge is therefore visible at the outputs right after that same edge.

Top module: `nest_irq_ctrl`

## Requirements
- R1: Vector index i (0..9) is issued with address 3 + 8*i on `vec_addr_o` (0x03, 0x0B, ... 0x4B).
- R2: Level mapping when `raise_i[i]` is 1:
  - vectors 0 and 1 run at the top level;
  - vectors 2..9 run at the high level.
  When `raise_i[i]` is 0, the vector runs at the low level. `svc_lvl_o` has one bit per level: bit 0 low, bit 1 high, bit 2 top.
- R3: Among pending requests at different levels, the one at the higher level is issued (top > high > low).
- R4: Among pending requests at the same level, the lowest vector index is issued.
- R5: A pending request is issued only when its level is strictly above the highest level set in `svc_lvl_o`, or when `svc_lvl_o` is zero.
- R6: A request held on `req_i` for a single cycle stays pending until it is acknowledged. A request that is not currently allowed is issued later, once the conditions allow it.
- R7: `ack_i` while `irq_o` is 1 clears the issued vector's pending state and sets that vector's level bit in `svc_lvl_o`. `ack_i` while `irq_o` is 0 has no effect.
- R8: `reti_i` clears the highest set bit of `svc_lvl_o`. With `svc_lvl_o` at zero it has no effect.
- R9: A request present at a clock edge drives `irq_o` and `vec_addr_o` right after that edge.
- R10: While `enable_i` is 0, `irq_o` stays 0 from the next cycle on, but requests stay pending. They are issued one cycle after `enable_i` returns to 1.
- R11: Reset clears all pending requests and in-service levels, and drives `irq_o` and `vec_addr_o` to 0.
- R12: `vec_addr_o` is 0 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Global interrupt enable |
| req_i | input | 10 | Request line per vector |
| raise_i | input | 10 | Per-vector level setting (1 = top/high, 0 = low) |
| ack_i | input | 1 | CPU accepts the issued vector |
| reti_i | input | 1 | Return from interrupt |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 7 | Entry address of the issued vector |
| svc_lvl_o | output | 3 | In-service level bits (bit 2 top, bit 1 high, bit 0 low) |

## Verification
The hardest situation to reach is a request that is blocked by an equal or higher level in service. It must then be issued exactly at the return that uncovers it.

The bench creates this state in two ways:
- It sweeps every pair of vectors under all four level settings. It acknowledges the winner, checks that the loser is held back, and checks that the loser appears on the cycle of the return.
- It builds a three-deep nest of low, high and top handlers. It then places a high request behind them and unwinds the nest one return at a time.

// File: rtl/nirq_pkg.sv
package nirq_pkg;
  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_TOP  = 2'd2
  } lvl_e;

  localparam int NUM_LVL = 3;
endpackage

// File: rtl/nirq_level_map.sv
module nirq_level_map
  import nirq_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int NUM_TOP = 2
) (
  input  logic [NUM_VEC-1:0]      raise_i,
  output logic [NUM_VEC-1:0][1:0] lvl_o
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_map
    if (g < NUM_TOP) begin : g_top
      assign lvl_o[g] = raise_i[g] ? LVL_TOP : LVL_LOW;
    end else begin : g_high
      assign lvl_o[g] = raise_i[g] ? LVL_HIGH : LVL_LOW;
    end
  end
endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
  import nirq_pkg::*;
#(
  parameter int NUM_VEC = 10,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0]      pend_i,
  input  logic [NUM_VEC-1:0][1:0] lvl_i,
  output logic                    win_vld_o,
  output logic [IDX_W-1:0]        win_idx_o,
  output logic [1:0]              win_lvl_o
);
  // higher level overwrites; within a level the lowest index is visited last
  always_comb begin
    win_vld_o = 1'b0;
    win_idx_o = '0;
    win_lvl_o = LVL_LOW;
    for (int l = 0; l < NUM_LVL; l++) begin
      for (int v = NUM_VEC - 1; v >= 0; v--) begin
        if (pend_i[v] && (lvl_i[v] == 2'(l))) begin
          win_vld_o = 1'b1;
          win_idx_o = IDX_W'(v);
          win_lvl_o = 2'(l);
        end
      end
    end
  end
endmodule

// File: rtl/nirq_nest_stack.sv
module nirq_nest_stack
  import nirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pop_i,
  input  logic               push_i,
  input  logic [1:0]         push_lvl_i,
  output logic [NUM_LVL-1:0] stk_o,
  output logic               top_vld_o,
  output logic [1:0]         top_lvl_o
);
  logic [NUM_LVL-1:0] stk_q, stk_n;

  always_comb begin
    logic done;
    stk_n = stk_q;
    done  = 1'b0;
    if (pop_i) begin
      for (int l = NUM_LVL - 1; l >= 0; l--) begin
        if (!done && stk_n[l]) begin
          stk_n[l] = 1'b0;
          done     = 1'b1;
        end
      end
    end
    if (push_i) stk_n[push_lvl_i] = 1'b1;
  end

  // current level taken from next state so grants track this cycle's push/pop
  always_comb begin
    top_vld_o = 1'b0;
    top_lvl_o = LVL_LOW;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (stk_n[l]) begin
        top_vld_o = 1'b1;
        top_lvl_o = 2'(l);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stk_q <= '0;
    else         stk_q <= stk_n;
  end

  assign stk_o = stk_q;
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
  import nirq_pkg::*;
#(
  parameter int NUM_VEC    = 10,
  parameter int NUM_TOP    = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [NUM_VEC-1:0] req_i,
  input  logic [NUM_VEC-1:0] raise_i,
  input  logic               ack_i,
  input  logic               reti_i,
  output logic               irq_o,
  output logic [ADDR_W-1:0]  vec_addr_o,
  output logic [NUM_LVL-1:0] svc_lvl_o
);
  localparam int IDX_W = $clog2(NUM_VEC);

  logic [NUM_VEC-1:0]      pend_q, pend_n, clr_mask;
  logic [NUM_VEC-1:0][1:0] lvl;
  logic                    irq_q;
  logic [IDX_W-1:0]        idx_q;
  logic [1:0]              lvl_q;
  logic [ADDR_W-1:0]       addr_q;
  logic                    ack_hit;
  logic                    win_vld, top_vld, grant;
  logic [IDX_W-1:0]        win_idx;
  logic [1:0]              win_lvl, top_lvl;

  assign ack_hit  = ack_i & irq_q;
  assign clr_mask = ack_hit ? (NUM_VEC'(1) << idx_q) : '0;
  assign pend_n   = (pend_q | req_i) & ~clr_mask;

  nirq_level_map #(
    .NUM_VEC(NUM_VEC),
    .NUM_TOP(NUM_TOP)
  ) i_map (
    .raise_i(raise_i),
    .lvl_o  (lvl)
  );

  nirq_arbiter #(
    .NUM_VEC(NUM_VEC),
    .IDX_W  (IDX_W)
  ) i_arb (
    .pend_i   (pend_n & {NUM_VEC{enable_i}}),
    .lvl_i    (lvl),
    .win_vld_o(win_vld),
    .win_idx_o(win_idx),
    .win_lvl_o(win_lvl)
  );

  nirq_nest_stack i_stk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pop_i     (reti_i),
    .push_i    (ack_hit),
    .push_lvl_i(lvl_q),
    .stk_o     (svc_lvl_o),
    .top_vld_o (top_vld),
    .top_lvl_o (top_lvl)
  );

  assign grant = win_vld & (!top_vld || (win_lvl > top_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= LVL_LOW;
      addr_q <= '0;
    end else begin
      pend_q <= pend_n;
      irq_q  <= grant;
      idx_q  <= grant ? win_idx : '0;
      lvl_q  <= grant ? win_lvl : LVL_LOW;
      addr_q <= grant ? ADDR_W'(VEC_BASE + VEC_STRIDE * int'(win_idx)) : '0;
    end
  end

  assign irq_o      = irq_q;
  assign vec_addr_o = addr_q;
endmodule

// File: rtl/nirq_chk.sv
module nirq_chk #(
  parameter int NUM_VEC    = 10,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  parameter int ADDR_W     = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              enable_i,
  input logic              ack_i,
  input logic              reti_i,
  input logic              irq_o,
  input logic [ADDR_W-1:0] vec_addr_o,
  input logic [2:0]        svc_lvl_o
);
  localparam int MAX_ADDR = VEC_BASE + VEC_STRIDE * (NUM_VEC - 1);

  // R1
  addr_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (int'(vec_addr_o) >= VEC_BASE) && (int'(vec_addr_o) <= MAX_ADDR) &&
              (((int'(vec_addr_o) - VEC_BASE) % VEC_STRIDE) == 0));

  // R12
  addr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (vec_addr_o == '0));

  // R5
  top_blocks_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_lvl_o[2] |-> !irq_o);

  // R7
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !reti_i) |=> ($countones(svc_lvl_o) == $countones($past(svc_lvl_o)) + 1));

  // R8
  reti_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !(ack_i && irq_o) && (svc_lvl_o != '0)) |=>
      ($countones(svc_lvl_o) == $countones($past(svc_lvl_o)) - 1));

  // R10
  disable_mutes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !irq_o);
endmodule

bind nest_irq_ctrl nirq_chk #(
  .NUM_VEC   (NUM_VEC),
  .VEC_BASE  (VEC_BASE),
  .VEC_STRIDE(VEC_STRIDE),
  .ADDR_W    (ADDR_W)
) i_nirq_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .ack_i     (ack_i),
  .reti_i    (reti_i),
  .irq_o     (irq_o),
  .vec_addr_o(vec_addr_o),
  .svc_lvl_o (svc_lvl_o)
);

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
  localparam int NV = 10;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          enable_i = 1'b0;
  logic [NV-1:0] req_i = '0;
  logic [NV-1:0] raise_i = '0;
  logic          ack_i = 1'b0;
  logic          reti_i = 1'b0;
  logic          irq_o;
  logic [6:0]    vec_addr_o;
  logic [2:0]    svc_lvl_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  nest_irq_ctrl i_nest_irq_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .req_i     (req_i),
    .raise_i   (raise_i),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .irq_o     (irq_o),
    .vec_addr_o(vec_addr_o),
    .svc_lvl_o (svc_lvl_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic int rank(int i, bit hi);
    if (!hi) return 0;
    return (i < 2) ? 2 : 1;
  endfunction

  function automatic int addr_of(int i);
    return 3 + 8 * i;
  endfunction

  task automatic do_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic do_reti();
    reti_i = 1'b1; step(); reti_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #15;
    chk("R11 reset irq", 32'(irq_o), 0);
    chk("R11 reset addr", 32'(vec_addr_o), 0);
    chk("R11 reset svc", 32'(svc_lvl_o), 0);
    rst_ni = 1'b1;
    enable_i = 1'b1;
    step();

    // single vectors, both settings
    for (int i = 0; i < NV; i++) begin
      for (int h = 0; h < 2; h++) begin
        raise_i = '0; raise_i[i] = h[0];
        req_i[i] = 1'b1; step(); req_i = '0;
        chk("R9 irq after edge", 32'(irq_o), 1);
        chk("R1 address", 32'(vec_addr_o), 32'(addr_of(i)));
        step();
        chk("R6 held pending", 32'(irq_o), 1);
        do_ack();
        chk("R7 irq drops", 32'(irq_o), 0);
        chk("R12 idle addr", 32'(vec_addr_o), 0);
        chk("R2 level bit", 32'(svc_lvl_o), 32'(1 << rank(i, h[0])));
        do_reti();
        chk("R8 pop", 32'(svc_lvl_o), 0);
        chk("R7 pending cleared", 32'(irq_o), 0);
      end
    end

    // every pair, every setting combination
    for (int i = 0; i < NV; i++) begin
      for (int j = i + 1; j < NV; j++) begin
        for (int c = 0; c < 4; c++) begin
          int ri, rj, w, l;
          ri = rank(i, c[0]); rj = rank(j, c[1]);
          w = (rj > ri) ? j : i;
          l = (w == i) ? j : i;
          raise_i = '0; raise_i[i] = c[0]; raise_i[j] = c[1];
          req_i[i] = 1'b1; req_i[j] = 1'b1; step(); req_i = '0;
          chk((ri != rj) ? "R3 level wins" : "R4 low index wins",
              32'(vec_addr_o), 32'(addr_of(w)));
          do_ack();
          chk("R5 equal/lower blocked", 32'(irq_o), 0);
          chk("R2 svc after ack", 32'(svc_lvl_o), 32'(1 << ((w == i) ? ri : rj)));
          do_reti();
          chk("R6 loser issued", 32'(irq_o), 1);
          chk("R6 loser addr", 32'(vec_addr_o), 32'(addr_of(l)));
          do_ack();
          do_reti();
          chk("R8 empty", 32'(svc_lvl_o), 0);
          chk("R7 none left", 32'(irq_o), 0);
        end
      end
    end

    // nesting low -> high -> top, then a blocked high request
    raise_i = '0; raise_i[4] = 1'b1; raise_i[0] = 1'b1; raise_i[5] = 1'b1;
    req_i[9] = 1'b1; step(); req_i = '0;
    chk("R1 vec9", 32'(vec_addr_o), 75);
    do_ack();
    chk("R7 svc low", 32'(svc_lvl_o), 1);
    req_i[4] = 1'b1; step(); req_i = '0;
    chk("R5 high over low", 32'(vec_addr_o), 35);
    do_ack();
    chk("R7 svc low+high", 32'(svc_lvl_o), 3);
    req_i[0] = 1'b1; step(); req_i = '0;
    chk("R5 top over high", 32'(vec_addr_o), 3);
    do_ack();
    chk("R7 svc all", 32'(svc_lvl_o), 7);
    req_i[5] = 1'b1; step(); req_i = '0;
    chk("R5 high under top", 32'(irq_o), 0);
    step();
    chk("R5 still blocked", 32'(irq_o), 0);
    do_reti();
    chk("R8 pop top", 32'(svc_lvl_o), 3);
    chk("R5 high equal blocked", 32'(irq_o), 0);
    do_reti();
    chk("R8 pop high", 32'(svc_lvl_o), 1);
    chk("R6 released", 32'(irq_o), 1);
    chk("R6 released addr", 32'(vec_addr_o), 43);
    do_ack();
    chk("R7 push high", 32'(svc_lvl_o), 3);
    do_reti();
    do_reti();
    chk("R8 unwound", 32'(svc_lvl_o), 0);
    chk("R8 nothing pending", 32'(irq_o), 0);

    // global enable
    enable_i = 1'b0; raise_i = '0;
    req_i[3] = 1'b1; step(); req_i = '0;
    chk("R10 muted", 32'(irq_o), 0);
    step();
    chk("R10 muted again", 32'(irq_o), 0);
    enable_i = 1'b1; step();
    chk("R10 resumes", 32'(irq_o), 1);
    chk("R10 kept addr", 32'(vec_addr_o), 27);
    do_ack();
    do_reti();

    // stray strobes
    do_ack();
    chk("R7 stray ack", 32'(svc_lvl_o), 0);
    chk("R7 stray ack irq", 32'(irq_o), 0);
    do_reti();
    chk("R8 empty reti", 32'(svc_lvl_o), 0);

    // reset mid-flight
    raise_i = '0; raise_i[2] = 1'b1;
    req_i[2] = 1'b1; req_i[6] = 1'b1; step(); req_i = '0;
    do_ack();
    rst_ni = 1'b0; #3;
    chk("R11 svc cleared", 32'(svc_lvl_o), 0);
    chk("R11 irq cleared", 32'(irq_o), 0);
    step();
    rst_ni = 1'b1; step();
    chk("R11 pending dropped", 32'(irq_o), 0);
    chk("R11 addr zero", 32'(vec_addr_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule